// File: doc/BRIEF.md
# Dual DAC Serial Command Decoder

This block is the digital control core of a two-channel, 10-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial slave port (active-low chip select, serial clock, serial data). Each channel has a staging register and a live output register. A command can stage a code, publish staged codes to the outputs one channel at a time or both together, or do both in one word. It can also put either channel into shutdown with a chosen output termination, or drop the shared bias into a full power-down. A separate active-low load strobe publishes both staged codes without a serial transaction.

All four pins are resynchronised into the system clock domain, and edges are found there. The serial clock must therefore run at no more than a quarter of the system clock. The serial port is a plain slave with no back-pressure: a word is accepted whenever the host completes it. Outputs are the two live codes, a powered flag and a termination select per channel, and a bias-enable flag, all meant to steer the analog section.

A word is the control field in bits 15..13, then the code in bits 12..3 with its most significant bit first on the wire, then a three-bit tail in bits 2..0. The bits are shifted in while chip select is low and executed when chip select returns high.

Top module: `dac_cmd_core`

## Requirements
- R1: A word executes on the chip-select rising edge only if exactly 16 serial clock rising edges were seen while chip select was low. Any other count leaves every register and flag unchanged.
- R2: A word whose tail (bits 2..0) is not 000 has no effect.
- R3: Control 010 writes the code to staging A, and control 101 writes it to staging B. Live outputs and power flags stay unchanged.
- R4: Control 001 writes staging A and control 110 writes staging B. In both cases the two live outputs then take the updated staging values.
- R5: Control 011 writes the code to both staging and both live registers. Control 100 copies each staging register to its live register.
- R6: Control 111 shuts down both channels, with the termination of A taken from code bit 9 and that of B from code bit 8. The bias flag is not changed.
- R7: With control 000, code bits 9..7 form a sub-command. Sub-command 001 copies staging A to live A and powers A, and 101 does the same for B. The other channel is left untouched.
- R8: Sub-command 011 (control 000) is a full power-down. The bias flag drops and both channels shut down, with terminations from code bit 6 (A) and code bit 5 (B).
- R9: Sub-command 110 shuts down A with termination from code bit 6, and 111 does the same for B. The other channel and the bias are unchanged.
- R10: Every live-register write powers that channel, and any such write turns the bias flag back on. The bias is never off while a channel is powered.
- R11: While the load strobe is low, both live registers copy their staging registers, and the power flags and terminations are untouched. A command executing in the same cycle takes precedence.
- R12: After reset, all codes are zero, both channels are powered, both terminations are 0 (0 = low-ohm load, 1 = high-ohm load), and the bias flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low strobe publishing both staged codes |
| code_a | output | 10 | Live code of channel A |
| code_b | output | 10 | Live code of channel B |
| pwr_a | output | 1 | Channel A powered (0 = shut down) |
| pwr_b | output | 1 | Channel B powered (0 = shut down) |
| term_a | output | 1 | Channel A shutdown termination select |
| term_b | output | 1 | Channel B shutdown termination select |
| bias_on | output | 1 | Shared bias enabled |

## Verification
The bench targets the interplay of shutdown, wake-up and bias. A channel woken from full power-down must bring the bias back while its neighbour stays off. A design that gated the bias on both channels, or woke both channels, would show the wrong flags. Staging-only writes are checked for leaking into the live outputs, and the load strobe is checked for publishing codes without waking a shut-down channel. Frames of 15 and 17 bits and words with a nonzero tail are sent with payloads that would visibly change the outputs, so a decoder that counts loosely or ignores the tail would alter the codes.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CODE_W  = 10;
  localparam int CTRL_W  = 3;
  localparam int TAIL_W  = 3;
  localparam int FRAME_W = CTRL_W + CODE_W + TAIL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [CTRL_W-1:0] {
    OP_EXT      = 3'b000,
    OP_STA_PUB  = 3'b001,
    OP_STA      = 3'b010,
    OP_ALL      = 3'b011,
    OP_PUB      = 3'b100,
    OP_STB      = 3'b101,
    OP_STB_PUB  = 3'b110,
    OP_SD_BOTH  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    XOP_WAKE_A = 3'b001,
    XOP_FULLPD = 3'b011,
    XOP_WAKE_B = 3'b101,
    XOP_SD_A   = 3'b110,
    XOP_SD_B   = 3'b111
  } xop_e;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic pub_a;
    logic pub_b;
    logic sd_a;
    logic sd_b;
    logic sel_a;
    logic sel_b;
    logic bias_off;
  } act_t;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {2{IDLE[g]}};
      else        stg <= {stg[0], async_in[g]};
    end
    assign sync_out[g] = stg[1];
  end
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_lvl,
  input  logic               sclk_lvl,
  input  logic               sdi_lvl,
  output logic               frame_v,
  output logic [FRAME_W-1:0] frame_word
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic cs_q, sclk_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic cs_rise, cs_fall, bit_take;

  assign cs_rise  = cs_lvl & ~cs_q;
  assign cs_fall  = ~cs_lvl & cs_q;
  assign bit_take = sclk_lvl & ~sclk_q & ~cs_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_lvl;
      sclk_q <= sclk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (bit_take) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_lvl};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  assign frame_v    = cs_rise && (cnt == CNT_FULL);
  assign frame_word = shreg;

  p_hold_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_take |=> $stable(shreg));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic               frame_v,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               cmd_v,
  output act_t               act,
  output logic [CODE_W-1:0]  code
);
  logic [CTRL_W-1:0] ctrl;
  logic [TAIL_W-1:0] tail;
  logic [2:0]        xop;
  logic              b6, b5, b9, b8;

  assign ctrl = frame_word[FRAME_W-1 -: CTRL_W];
  assign code = frame_word[TAIL_W +: CODE_W];
  assign tail = frame_word[TAIL_W-1:0];
  assign xop  = code[CODE_W-1 -: 3];
  assign b9   = code[CODE_W-1];
  assign b8   = code[CODE_W-2];
  assign b6   = code[CODE_W-4];
  assign b5   = code[CODE_W-5];

  assign cmd_v = frame_v && (tail == '0);

  always_comb begin
    act = '0;
    unique case (op_e'(ctrl))
      OP_STA_PUB: begin act.wr_a = 1'b1; act.pub_a = 1'b1; act.pub_b = 1'b1; end
      OP_STA:     act.wr_a = 1'b1;
      OP_ALL:     begin act.wr_a = 1'b1; act.wr_b = 1'b1;
                        act.pub_a = 1'b1; act.pub_b = 1'b1; end
      OP_PUB:     begin act.pub_a = 1'b1; act.pub_b = 1'b1; end
      OP_STB:     act.wr_b = 1'b1;
      OP_STB_PUB: begin act.wr_b = 1'b1; act.pub_a = 1'b1; act.pub_b = 1'b1; end
      OP_SD_BOTH: begin act.sd_a = 1'b1; act.sd_b = 1'b1;
                        act.sel_a = b9; act.sel_b = b8; end
      OP_EXT: begin
        case (xop)
          XOP_WAKE_A: act.pub_a = 1'b1;
          XOP_WAKE_B: act.pub_b = 1'b1;
          XOP_FULLPD: begin act.sd_a = 1'b1; act.sd_b = 1'b1; act.bias_off = 1'b1;
                            act.sel_a = b6; act.sel_b = b5; end
          XOP_SD_A:   begin act.sd_a = 1'b1; act.sel_a = b6; end
          XOP_SD_B:   begin act.sd_b = 1'b1; act.sel_b = b6; end
          default:    act = '0;
        endcase
      end
      default: act = '0;
    endcase
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v,
  input  act_t              act,
  input  logic [CODE_W-1:0] code,
  input  logic              load_lvl,
  output logic [CODE_W-1:0] live_a,
  output logic [CODE_W-1:0] live_b,
  output logic              pwr_a,
  output logic              pwr_b,
  output logic              term_a,
  output logic              term_b,
  output logic              bias_on
);
  logic [CODE_W-1:0] stg_a, stg_b, nxt_a, nxt_b;
  logic strobe;

  assign strobe = ~load_lvl;
  assign nxt_a  = act.wr_a ? code : stg_a;
  assign nxt_b  = act.wr_b ? code : stg_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a  <= '0;
      stg_b  <= '0;
      live_a <= '0;
      live_b <= '0;
    end else if (cmd_v) begin
      stg_a <= nxt_a;
      stg_b <= nxt_b;
      if (act.pub_a) live_a <= nxt_a;
      if (act.pub_b) live_b <= nxt_b;
    end else if (strobe) begin
      live_a <= stg_a;
      live_b <= stg_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_a   <= 1'b1;
      pwr_b   <= 1'b1;
      term_a  <= 1'b0;
      term_b  <= 1'b0;
      bias_on <= 1'b1;
    end else if (cmd_v) begin
      if (act.pub_a) pwr_a <= 1'b1;
      else if (act.sd_a) begin pwr_a <= 1'b0; term_a <= act.sel_a; end
      if (act.pub_b) pwr_b <= 1'b1;
      else if (act.sd_b) begin pwr_b <= 1'b0; term_b <= act.sel_b; end
      if (act.pub_a || act.pub_b) bias_on <= 1'b1;
      else if (act.bias_off)      bias_on <= 1'b0;
    end
  end

  p_live_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_v && !strobe) |=> ($stable(live_a) && $stable(live_b)));
  p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_v |=> ($stable(stg_a) && $stable(stg_b)));
  p_bias_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_on |-> (!pwr_a && !pwr_b));
  p_wake_bias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_a) || $rose(pwr_b)) |-> bias_on);
  p_strobe_power_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !cmd_v) |=> ($stable(pwr_a) && $stable(pwr_b) && $stable(bias_on)
                            && $stable(term_a) && $stable(term_b)));
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              load_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              pwr_a,
  output logic              pwr_b,
  output logic              term_a,
  output logic              term_b,
  output logic              bias_on
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b1001;

  logic [NPIN-1:0]    pins_s;
  logic               frame_v, cmd_v;
  logic [FRAME_W-1:0] frame_word;
  logic [CODE_W-1:0]  code;
  act_t               act;

  dac_in_sync #(.N(NPIN), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({load_n, sdi, sclk, cs_n}),
    .sync_out(pins_s)
  );

  dac_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(pins_s[0]), .sclk_lvl(pins_s[1]), .sdi_lvl(pins_s[2]),
    .frame_v(frame_v), .frame_word(frame_word)
  );

  dac_cmd_decode u_dec (
    .frame_v(frame_v), .frame_word(frame_word),
    .cmd_v(cmd_v), .act(act), .code(code)
  );

  dac_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .cmd_v(cmd_v), .act(act), .code(code), .load_lvl(pins_s[3]),
    .live_a(code_a), .live_b(code_b),
    .pwr_a(pwr_a), .pwr_b(pwr_b),
    .term_a(term_a), .term_b(term_b), .bias_on(bias_on)
  );
endmodule

// File: tb/test_dac_cmd_core.sv
module test_dac_cmd_core;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
  logic [9:0] code_a, code_b;
  logic pwr_a, pwr_b, term_a, term_b, bias_on;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_core i_dac_cmd_core (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .load_n(load_n),
    .code_a(code_a), .code_b(code_b), .pwr_a(pwr_a), .pwr_b(pwr_b),
    .term_a(term_a), .term_b(term_b), .bias_on(bias_on)
  );

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] d,
                                     input logic [2:0] s);
    return {c, d, s};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    idle(HALF_BIT);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      idle(HALF_BIT);
      sclk = 1'b1;
      idle(HALF_BIT);
      sclk = 1'b0;
    end
    idle(HALF_BIT);
    cs_n = 1'b1;
    idle(12);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int oa, input int ob, input int pa,
                         input int pb, input int ta, input int tb, input int bi);
    chk(req, "code_a", int'(code_a), oa);
    chk(req, "code_b", int'(code_b), ob);
    chk(req, "pwr_a", int'(pwr_a), pa);
    chk(req, "pwr_b", int'(pwr_b), pb);
    chk(req, "term_a", int'(term_a), ta);
    chk(req, "term_b", int'(term_b), tb);
    chk(req, "bias_on", int'(bias_on), bi);
  endtask

  task automatic t_reset;
    chk_all("R12", 0, 0, 1, 1, 0, 0, 1);
  endtask

  task automatic t_stage_only;
    send(32'(mk(3'b010, 10'h155, 3'b000)), 16);
    chk_all("R3", 0, 0, 1, 1, 0, 0, 1);
    send(32'(mk(3'b101, 10'h2AA, 3'b000)), 16);
    chk_all("R3", 0, 0, 1, 1, 0, 0, 1);
    send(32'(mk(3'b100, 10'h3FF, 3'b000)), 16);
    chk_all("R5 R1", 'h155, 'h2AA, 1, 1, 0, 0, 1);
  endtask

  task automatic t_stage_publish;
    send(32'(mk(3'b001, 10'h0F0, 3'b000)), 16);
    chk_all("R4", 'h0F0, 'h2AA, 1, 1, 0, 0, 1);
    send(32'(mk(3'b110, 10'h3FF, 3'b000)), 16);
    chk_all("R4", 'h0F0, 'h3FF, 1, 1, 0, 0, 1);
  endtask

  task automatic t_load_all;
    send(32'(mk(3'b011, 10'h123, 3'b000)), 16);
    chk_all("R5", 'h123, 'h123, 1, 1, 0, 0, 1);
  endtask

  task automatic t_shut_both;
    send(32'(mk(3'b111, 10'h200, 3'b000)), 16);
    chk_all("R6", 'h123, 'h123, 0, 0, 1, 0, 1);
  endtask

  task automatic t_wake_a;
    send(32'(mk(3'b010, 10'h011, 3'b000)), 16);
    send(32'(mk(3'b000, 10'h080, 3'b000)), 16);
    chk_all("R7 R10", 'h011, 'h123, 1, 0, 1, 0, 1);
  endtask

  task automatic t_full_pd_and_wake_b;
    send(32'(mk(3'b000, 10'h1A0, 3'b000)), 16);
    chk_all("R8", 'h011, 'h123, 0, 0, 0, 1, 0);
    send(32'(mk(3'b101, 10'h0AA, 3'b000)), 16);
    chk_all("R3", 'h011, 'h123, 0, 0, 0, 1, 0);
    send(32'(mk(3'b000, 10'h280, 3'b000)), 16);
    chk_all("R7 R10", 'h011, 'h0AA, 0, 1, 0, 1, 1);
  endtask

  task automatic t_single_shutdown;
    send(32'(mk(3'b000, 10'h080, 3'b000)), 16);
    chk_all("R10", 'h011, 'h0AA, 1, 1, 0, 1, 1);
    send(32'(mk(3'b000, 10'h340, 3'b000)), 16);
    chk_all("R9", 'h011, 'h0AA, 0, 1, 1, 1, 1);
    send(32'(mk(3'b000, 10'h380, 3'b000)), 16);
    chk_all("R9", 'h011, 'h0AA, 0, 0, 1, 0, 1);
  endtask

  task automatic t_bad_length;
    logic [15:0] w;
    w = mk(3'b011, 10'h3C3, 3'b000);
    send(32'(w[15:1]), 15);
    chk_all("R1", 'h011, 'h0AA, 0, 0, 1, 0, 1);
    send({16'h0, w}, 17);
    chk_all("R1", 'h011, 'h0AA, 0, 0, 1, 0, 1);
  endtask

  task automatic t_bad_tail;
    send(32'(mk(3'b011, 10'h3C3, 3'b100)), 16);
    chk_all("R2", 'h011, 'h0AA, 0, 0, 1, 0, 1);
    send(32'(mk(3'b000, 10'h080, 3'b001)), 16);
    chk_all("R2", 'h011, 'h0AA, 0, 0, 1, 0, 1);
  endtask

  task automatic t_strobe;
    send(32'(mk(3'b010, 10'h001, 3'b000)), 16);
    send(32'(mk(3'b101, 10'h3FE, 3'b000)), 16);
    chk_all("R3", 'h011, 'h0AA, 0, 0, 1, 0, 1);
    load_n = 1'b0;
    idle(6);
    load_n = 1'b1;
    idle(6);
    chk_all("R11", 'h001, 'h3FE, 0, 0, 1, 0, 1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_stage_only();
    t_stage_publish();
    t_load_all();
    t_shut_both();
    t_wake_a();
    t_full_pd_and_wake_b();
    t_single_shutdown();
    t_bad_length();
    t_bad_tail();
    t_strobe();
    finish_run();
  end
endmodule